// File: doc/BRIEF.md
# Port-Mapped Register Bank with Interrupt Combiner

This block sits on the 8-bit I/O port bus of a small embedded controller. It offers sixteen general-purpose 8-bit storage registers, a read-only status register that samples the serial FIFO flags and the modem handshake lines, and a read/write interrupt mask register. Each of these appears at one port address. A decoder picks exactly one register for each read or write strobe.

The block also merges every masked status event onto the controller's single interrupt request line. That line is a registered level. It stays high while any enabled source remains active. Software finds the cause by reading the status and mask registers. The block does not encode the source.

The general-purpose registers occupy `GP_COUNT` consecutive addresses starting at `GP_BASE`. The status and mask registers sit at `STAT_ADDR` and `MASK_ADDR`. The defaults are 0x20..0x2F, 0x30 and 0x31.

Top module: `ioreg_bank`

## Requirements
- R1: After a synchronous reset, all general-purpose registers and the mask register hold 0x00, `rd_data` is 0x00 and `irq` is low.
- R2: A write strobe at address `GP_BASE+k` updates general-purpose register k only. Every other general-purpose register keeps its value.
- R3: A read strobe sampled at a rising edge places the addressed register's value on `rd_data` after that edge. In any cycle that follows an edge without a read strobe, `rd_data` is 0x00.
- R4: The status register at `STAT_ADDR` reads the event inputs sampled one edge earlier, with this layout: bit 0 rx data present, bit 1 rx full, bit 2 tx half full, bit 3 tx full, bit 4 CTS, bit 5 DSR, bit 6 RTS. The register is read-only, and a write to its address changes no state.
- R5: The mask register at `MASK_ADDR` is readable and writable over all 8 bits.
- R6: `irq` is the registered OR over all bit positions of (status AND mask). It rises two edges after an event input rises while its mask bit is already set. It rises one edge after a mask write that enables an active status bit. With a zero mask, `irq` stays low.
- R7: `irq` is level-sensitive. It stays high while a masked source stays active, and it falls two edges after the last masked source clears.
- R8: A read at an unmapped address returns 0x00. A write at an unmapped address changes no register.
- R9: Status bit 7 always reads 0, so mask bit 7 alone can never raise `irq`.
- R10: When a read and a write hit the same address at the same edge, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 8 | Port address |
| wr_data | input | 8 | Write data |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| ev_rx_avail | input | 1 | Receive FIFO holds data |
| ev_rx_full | input | 1 | Receive FIFO full |
| ev_tx_half | input | 1 | Transmit FIFO half full |
| ev_tx_full | input | 1 | Transmit FIFO full |
| ln_cts | input | 1 | Clear-to-send line |
| ln_dsr | input | 1 | Data-set-ready line |
| ln_rts | input | 1 | Request-to-send line |
| irq | output | 1 | Level interrupt request |

## Verification
A decoder fault that enables a second register shows up at the next read of a neighbouring register. This is why the bench fills all sixteen registers with distinct values and then reads every one of them. A stale status or mask flop shows up on `irq` within two edges, and the bench samples `irq` at each of those edges to pin the exact latency. A read mux that drives a non-selected source shows up as non-zero data on an unmapped or idle read in the very next cycle.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
  localparam int unsigned BYTE_W = 8;

  // status bit positions (software decodes these)
  localparam int unsigned ST_RX_AVAIL = 0;
  localparam int unsigned ST_RX_FULL  = 1;
  localparam int unsigned ST_TX_HALF  = 2;
  localparam int unsigned ST_TX_FULL  = 3;
  localparam int unsigned ST_CTS      = 4;
  localparam int unsigned ST_DSR      = 5;
  localparam int unsigned ST_RTS      = 6;

  typedef struct packed {
    logic rts;
    logic dsr;
    logic cts;
    logic tx_full;
    logic tx_half;
    logic rx_full;
    logic rx_avail;
  } ev_t;

  function automatic logic [BYTE_W-1:0] pack_status(input ev_t ev);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_RX_AVAIL] = ev.rx_avail;
    s[ST_RX_FULL]  = ev.rx_full;
    s[ST_TX_HALF]  = ev.tx_half;
    s[ST_TX_FULL]  = ev.tx_full;
    s[ST_CTS]      = ev.cts;
    s[ST_DSR]      = ev.dsr;
    s[ST_RTS]      = ev.rts;
    return s;
  endfunction
endpackage

// File: rtl/ioreg_decode.sv
module ioreg_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned GP_COUNT  = 16,
  parameter logic [ADDR_W-1:0] GP_BASE   = 8'h20,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h30,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h31
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [GP_COUNT-1:0] gp_sel,
  output logic                stat_sel,
  output logic                mask_sel
);
  for (genvar i = 0; i < GP_COUNT; i++) begin : g_sel
    assign gp_sel[i] = (addr == ADDR_W'(int'(GP_BASE) + i));
  end

  assign stat_sel = (addr == STAT_ADDR);
  assign mask_sel = (addr == MASK_ADDR);
endmodule

// File: rtl/ioreg_gpfile.sv
module ioreg_gpfile #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned GP_COUNT = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [GP_COUNT-1:0]        sel,
  input  logic                       wr_stb,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_val,
  output logic [GP_COUNT*DATA_W-1:0] gp_flat
);
  logic [DATA_W-1:0] regs   [GP_COUNT];
  logic [DATA_W-1:0] masked [GP_COUNT];

  for (genvar i = 0; i < GP_COUNT; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_stb && sel[i])
        regs[i] <= wr_data;
    end
    // only the selected register contributes to the read bus
    assign masked[i] = sel[i] ? regs[i] : '0;
    assign gp_flat[i*DATA_W +: DATA_W] = regs[i];
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < GP_COUNT; i++)
      rd_val = rd_val | masked[i];
  end
endmodule

// File: rtl/ioreg_irq.sv
module ioreg_irq
  import ioreg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ev_t               ev,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              irq
);
  logic [DATA_W-1:0] stat_d;
  logic              irq_d;

  assign stat_d = DATA_W'(pack_status(ev));
  assign irq_d  = |(stat_q & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (mask_wr)
        mask_q <= wr_data;
      irq <= irq_d;
    end
  end
endmodule

// File: rtl/ioreg_bank.sv
module ioreg_bank
  import ioreg_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned GP_COUNT  = 16,
  parameter logic [ADDR_W-1:0] GP_BASE   = 8'h20,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h30,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_stb,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_rx_avail,
  input  logic              ev_rx_full,
  input  logic              ev_tx_half,
  input  logic              ev_tx_full,
  input  logic              ln_cts,
  input  logic              ln_dsr,
  input  logic              ln_rts,
  output logic              irq
);
  localparam int unsigned FLAT_W = GP_COUNT * DATA_W;

  logic [GP_COUNT-1:0] gp_sel;
  logic                stat_sel;
  logic                mask_sel;
  logic [DATA_W-1:0]   gp_rd;
  logic [FLAT_W-1:0]   gp_flat;
  logic [DATA_W-1:0]   stat_q;
  logic [DATA_W-1:0]   mask_q;
  logic [DATA_W-1:0]   rd_mux;
  ev_t                 ev;

  assign ev = '{rts: ln_rts, dsr: ln_dsr, cts: ln_cts, tx_full: ev_tx_full,
                tx_half: ev_tx_half, rx_full: ev_rx_full, rx_avail: ev_rx_avail};

  ioreg_decode #(
    .ADDR_W(ADDR_W), .GP_COUNT(GP_COUNT), .GP_BASE(GP_BASE),
    .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_decode (
    .addr(port_addr), .gp_sel(gp_sel), .stat_sel(stat_sel), .mask_sel(mask_sel)
  );

  ioreg_gpfile #(.DATA_W(DATA_W), .GP_COUNT(GP_COUNT)) u_gpfile (
    .clk(clk), .rst(rst), .sel(gp_sel), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_val(gp_rd), .gp_flat(gp_flat)
  );

  ioreg_irq #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .ev(ev), .mask_wr(wr_stb && mask_sel),
    .wr_data(wr_data), .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
  );

  // AND-OR read mux: unmapped addresses select nothing and yield zero
  assign rd_mux = gp_rd
                | (stat_sel ? stat_q : '0)
                | (mask_sel ? mask_q : '0);

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else
      rd_data <= rd_stb ? rd_mux : '0;
  end
endmodule

// File: rtl/ioreg_bank_chk.sv
module ioreg_bank_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned GP_COUNT  = 16,
  parameter logic [ADDR_W-1:0] GP_BASE   = 8'h20,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h30,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h31
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          port_addr,
  input logic                       wr_stb,
  input logic                       rd_stb,
  input logic [DATA_W-1:0]          rd_data,
  input logic                       irq,
  input logic [DATA_W-1:0]          mask_q,
  input logic [GP_COUNT*DATA_W-1:0] gp_flat
);
  logic in_gp, unmapped, hit_stat;

  assign in_gp    = (int'(port_addr) >= int'(GP_BASE)) &&
                    (int'(port_addr) <  int'(GP_BASE) + int'(GP_COUNT));
  assign hit_stat = (port_addr == STAT_ADDR);
  assign unmapped = !in_gp && !hit_stat && (port_addr != MASK_ADDR);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !irq && mask_q == '0)); // R1

  AST_GP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(gp_flat)); // R2

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> rd_data == '0); // R3

  AST_STATUS_RO: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && hit_stat) |=> ($stable(gp_flat) && $stable(mask_q))); // R4

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq); // R6

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && unmapped) |=> rd_data == '0); // R8

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && unmapped) |=> ($stable(gp_flat) && $stable(mask_q))); // R8

  AST_STAT_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && hit_stat) |=> !rd_data[DATA_W-1]); // R9
endmodule

bind ioreg_bank ioreg_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GP_COUNT(GP_COUNT),
  .GP_BASE(GP_BASE), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .port_addr(port_addr), .wr_stb(wr_stb),
  .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq), .mask_q(mask_q),
  .gp_flat(gp_flat)
);

// File: tb/test_ioreg_bank.sv
module test_ioreg_bank;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] port_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_stb = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       ev_rx_avail = 0, ev_rx_full = 0, ev_tx_half = 0, ev_tx_full = 0;
  logic       ln_cts = 0, ln_dsr = 0, ln_rts = 0;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioreg_bank i_ioreg_bank (
    .clk(clk), .rst(rst), .port_addr(port_addr), .wr_data(wr_data),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_data(rd_data),
    .ev_rx_avail(ev_rx_avail), .ev_rx_full(ev_rx_full),
    .ev_tx_half(ev_tx_half), .ev_tx_full(ev_tx_full),
    .ln_cts(ln_cts), .ln_dsr(ln_dsr), .ln_rts(ln_rts), .irq(irq)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h20, 8'h11, 8'h00},
    '{1'b1, 8'h2F, 8'hF0, 8'h00},
    '{1'b1, 8'h27, 8'h5A, 8'h00},
    '{1'b0, 8'h20, 8'h00, 8'h11},
    '{1'b0, 8'h2F, 8'h00, 8'hF0},
    '{1'b0, 8'h27, 8'h00, 8'h5A},
    '{1'b0, 8'h21, 8'h00, 8'h00},
    '{1'b1, 8'h31, 8'h81, 8'h00},
    '{1'b0, 8'h31, 8'h00, 8'h81},
    '{1'b1, 8'h30, 8'hFF, 8'h00},
    '{1'b0, 8'h30, 8'h00, 8'h00},
    '{1'b1, 8'h40, 8'h77, 8'h00},
    '{1'b0, 8'h40, 8'h00, 8'h00},
    '{1'b0, 8'h1F, 8'h00, 8'h00},
    '{1'b1, 8'h31, 8'h00, 8'h00},
    '{1'b0, 8'h31, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    port_addr = a; wr_data = d; wr_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    port_addr = a; rd_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    do_read(8'h25, v); check("R1 gp", v, 8'h00);
    do_read(8'h31, v); check("R1 mask", v, 8'h00);

    // table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].data);
      else begin
        do_read(VEC[i].addr, v);
        check($sformatf("R3 R5 R8 table %0d", i), v, VEC[i].exp);
      end
    end

    // R3 idle read bus
    @(negedge clk);
    check("R3 idle", rd_data, 8'h00);

    // R2 isolation across all registers
    for (int k = 0; k < 16; k++) do_write(8'h20 + 8'(k), 8'(k*7 + 3));
    do_write(8'h26, 8'hC3);
    for (int k = 0; k < 16; k++) begin
      do_read(8'h20 + 8'(k), v);
      check($sformatf("R2 reg %0d", k), v, (k == 6) ? 8'hC3 : 8'(k*7 + 3));
    end

    // R10 read-before-write at same edge
    port_addr = 8'h22; wr_data = 8'h44; wr_stb = 1'b1; rd_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    check("R10 old value", rd_data, 8'h11);
    do_read(8'h22, v); check("R10 new value", v, 8'h44);

    // R4 status layout: rx_avail bit0, cts bit4, rts bit6 -> 0x51
    ev_rx_avail = 1; ln_cts = 1; ln_rts = 1;
    @(negedge clk);
    do_read(8'h30, v); check("R4 layout a", v, 8'h51);
    ev_rx_avail = 0; ln_cts = 0; ln_rts = 0;
    ev_rx_full = 1; ev_tx_half = 1; ev_tx_full = 1; ln_dsr = 1;
    @(negedge clk);
    do_read(8'h30, v); check("R4 layout b", v, 8'h2E);
    check("R6 zero mask", {7'd0, irq}, 8'h00);

    // R9 mask bit 7 alone cannot interrupt
    do_write(8'h31, 8'h80);
    @(negedge clk); @(negedge clk);
    check("R9 bit7 mask", {7'd0, irq}, 8'h00);

    // R6 mask write enabling active dsr (bit5): irq one edge later
    do_write(8'h31, 8'h20);
    check("R6 not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R6 mask rise", {7'd0, irq}, 8'h01);

    // R7 level hold, then fall two edges after clear
    repeat (3) @(negedge clk);
    check("R7 hold", {7'd0, irq}, 8'h01);
    ln_dsr = 0;
    @(negedge clk);
    check("R7 still high", {7'd0, irq}, 8'h01);
    @(negedge clk);
    check("R7 fall", {7'd0, irq}, 8'h00);

    // R6 event rise with mask already set: two edges
    ln_dsr = 1;
    @(negedge clk);
    check("R6 event edge1", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R6 event edge2", {7'd0, irq}, 8'h01);

    // R7 clearing mask drops irq
    do_write(8'h31, 8'h00);
    @(negedge clk);
    check("R7 mask clear", {7'd0, irq}, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule